// File: doc/BRIEF.md
# Prioritised Interrupt Evaluator and Vectoriser

This block sits beside a processor core and decides which interrupt, if any, the core should take next. It holds the pending requests from the fixed hardware sources (memory error, corrected-read error, interval timer, console input, console output and console storage). It also holds a bit vector of adapter requests for each of four hardware levels, with one bit per adapter slot. The halt pin and the 15-bit software request register are taken directly from inputs. Each cycle it compares all of this against the current processor priority level and drives the highest eligible level on `irq_lvl`. It drives zero when nothing qualifies.

When the core takes an interrupt, it presents the level on the acknowledge port. One cycle later the block returns the vector offset for that level and clears the one request it served. Adapter vectors are built from a base, the level and the slot number. Fixed sources have fixed vectors. An acknowledge above the hardware range that names no fixed source returns vector zero and raises an error flag.

Top module: `prio_irq_eval`

## Requirements
- R1: While `halt_req` is high, `irq_lvl` is 0x1F whatever `cur_ipl` holds.
- R2: Without halt, `irq_lvl` is chosen from the first eligible source in this order. The sources are memory error (0x1D), corrected-read error (0x1A), timer (0x18), adapter levels 0x17 down to 0x14, console (0x14) and then software. A source is eligible only when its level is strictly greater than `cur_ipl`. With no eligible source, `irq_lvl` is 0.
- R3: The adapter scan runs from 0x17 downward. The scan ends with no interrupt at the first level that is not above `cur_ipl`. An adapter level has a request when any of its slot bits is pending.
- R4: Bit k of `sw_req` is a request at level k+1. It is eligible only when k+1 > `cur_ipl`. No software level is produced when `cur_ipl` is 15 or more.
- R5: Acknowledging adapter level L returns 0x100 + (L-0x14)*0x40 + slot*4. The slot is the lowest-numbered pending slot of that level.
- R6: An adapter acknowledge clears only the slot bit it served. Bit i*16+s of `nx_set` sets slot s of level 0x14+i.
- R7: Acknowledging 0x14 with no adapter request at 0x14 serves console input (vector 0x0F8), else output (0x0FC), else storage (0x0F0). It clears only the request served.
- R8: `ack_done` pulses in the cycle after `ack_valid`. Acknowledging 0x1D, 0x1A or 0x18 returns 0x060, 0x054 or 0x0C0 respectively and clears that request.
- R9: An acknowledge for a level above 0x17 other than 0x1D, 0x1A or 0x18 returns vector 0 with `ack_err` high. An acknowledge of a level with nothing to serve returns vector 0 with `ack_err` low.
- R10: A set pulse and a clear of the same request in the same cycle leave the request pending. A request stays pending until it is served.
- R11: After reset nothing is pending and `irq_lvl`, `ack_done`, `ack_vec` and `ack_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cur_ipl | input | 5 | current processor priority level |
| halt_req | input | 1 | halt pin request (level) |
| mem_err_set | input | 1 | set memory-error request |
| crd_err_set | input | 1 | set corrected-read-error request |
| tmr_set | input | 1 | set interval-timer request |
| nx_set | input | 64 | per-level, per-slot adapter request set pulses |
| con_in_set | input | 1 | set console input request |
| con_out_set | input | 1 | set console output request |
| con_stor_set | input | 1 | set console storage request |
| sw_req | input | 15 | software request register, bit k = level k+1 |
| ack_valid | input | 1 | acknowledge strobe |
| ack_lvl | input | 5 | level being acknowledged |
| irq_lvl | output | 5 | highest eligible level, 0 if none |
| ack_done | output | 1 | acknowledge response valid |
| ack_vec | output | 16 | vector offset returned |
| ack_err | output | 1 | acknowledge of an unknown high level |

## Verification
The bench builds the block with its default parameters: sixteen slots on four adapter levels and a 16-bit vector. At these values the top slot at the top level produces the largest adapter vector, 0x1FC. They also make level 0x14 shared between adapters and console, so the adapter-before-console acknowledge order can be reached. Random priority levels across the full 0 to 31 range reach both software cut-offs and every adapter scan stop point.

// File: rtl/prio_irq_eval.sv
module prio_irq_eval #(
  parameter int NSLOT      = 16,
  parameter int NHWL       = 4,
  parameter int LW         = 5,
  parameter int VW         = 16,
  parameter int SW_MAX     = 15,
  parameter int HW_MIN     = 'h14,
  parameter int LVL_CON    = 'h14,
  parameter int LVL_TMR    = 'h18,
  parameter int LVL_CRD    = 'h1A,
  parameter int LVL_MEM    = 'h1D,
  parameter int LVL_HALT   = 'h1F,
  parameter int VEC_NX     = 'h100,
  parameter int VEC_MEM    = 'h060,
  parameter int VEC_CRD    = 'h054,
  parameter int VEC_TMR    = 'h0C0,
  parameter int VEC_TTI    = 'h0F8,
  parameter int VEC_TTO    = 'h0FC,
  parameter int VEC_CSI    = 'h0F0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LW-1:0]         cur_ipl,
  input  logic                  halt_req,
  input  logic                  mem_err_set,
  input  logic                  crd_err_set,
  input  logic                  tmr_set,
  input  logic [NHWL*NSLOT-1:0] nx_set,
  input  logic                  con_in_set,
  input  logic                  con_out_set,
  input  logic                  con_stor_set,
  input  logic [SW_MAX-1:0]     sw_req,
  input  logic                  ack_valid,
  input  logic [LW-1:0]         ack_lvl,
  output logic [LW-1:0]         irq_lvl,
  output logic                  ack_done,
  output logic [VW-1:0]         ack_vec,
  output logic                  ack_err
);
  localparam int HW_MAX = HW_MIN + NHWL - 1;

  logic             mem_q, crd_q, tmr_q;
  logic [2:0]       con_q;
  logic [NSLOT-1:0] nx_q   [NHWL];
  logic [NSLOT-1:0] nx_clr [NHWL];
  logic             mem_clr, crd_clr, tmr_clr;
  logic [2:0]       con_clr;
  logic [VW-1:0]    vec_d;
  logic             err_d;

  always_comb begin
    int c;
    int lvl;
    logic found, stop;
    c = int'(cur_ipl);
    lvl = 0;
    found = 1'b0;
    stop = 1'b0;
    if (halt_req)
      lvl = LVL_HALT;
    else if (mem_q && c < LVL_MEM)
      lvl = LVL_MEM;
    else if (crd_q && c < LVL_CRD)
      lvl = LVL_CRD;
    else if (tmr_q && c < LVL_TMR)
      lvl = LVL_TMR;
    else begin
      for (int i = NHWL - 1; i >= 0; i--) begin
        if (!found && !stop) begin
          if (HW_MIN + i <= c)
            stop = 1'b1;
          else if (|nx_q[i]) begin
            lvl = HW_MIN + i;
            found = 1'b1;
          end
        end
      end
      if (!found && !stop) begin
        if ((|con_q) && c < LVL_CON)
          lvl = LVL_CON;
        else if (c < SW_MAX)
          for (int n = 1; n <= SW_MAX; n++)
            if (n > c && sw_req[n-1]) lvl = n;
      end
    end
    irq_lvl = LW'(lvl);
  end

  always_comb begin
    int a;
    int v;
    int slo;
    logic hit;
    logic [NSLOT-1:0] sel;
    a = int'(ack_lvl);
    v = 0;
    slo = 0;
    hit = 1'b0;
    sel = '0;
    err_d = 1'b0;
    mem_clr = 1'b0;
    crd_clr = 1'b0;
    tmr_clr = 1'b0;
    con_clr = 3'b000;
    for (int i = 0; i < NHWL; i++) nx_clr[i] = '0;
    if (ack_valid) begin
      if (a == LVL_MEM) begin
        mem_clr = 1'b1;
        v = VEC_MEM;
      end else if (a == LVL_CRD) begin
        crd_clr = 1'b1;
        v = VEC_CRD;
      end else if (a == LVL_TMR) begin
        tmr_clr = 1'b1;
        v = VEC_TMR;
      end else if (a > HW_MAX) begin
        err_d = 1'b1;
      end else begin
        for (int i = 0; i < NHWL; i++)
          if (a == HW_MIN + i) sel = nx_q[i];
        if (|sel) begin
          for (int s = NSLOT - 1; s >= 0; s--)
            if (sel[s]) slo = s;
          for (int i = 0; i < NHWL; i++)
            if (a == HW_MIN + i) nx_clr[i][slo] = 1'b1;
          v = VEC_NX + (a - HW_MIN) * 'h40 + slo * 4;
          hit = 1'b1;
        end
        if (!hit && a == LVL_CON) begin
          if (con_q[0]) begin
            con_clr[0] = 1'b1;
            v = VEC_TTI;
          end else if (con_q[1]) begin
            con_clr[1] = 1'b1;
            v = VEC_TTO;
          end else if (con_q[2]) begin
            con_clr[2] = 1'b1;
            v = VEC_CSI;
          end
        end
      end
    end
    vec_d = VW'(v);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q    <= 1'b0;
      crd_q    <= 1'b0;
      tmr_q    <= 1'b0;
      con_q    <= 3'b000;
      for (int i = 0; i < NHWL; i++) nx_q[i] <= '0;
      ack_done <= 1'b0;
      ack_vec  <= '0;
      ack_err  <= 1'b0;
    end else begin
      mem_q    <= mem_err_set | (mem_q & ~mem_clr);
      crd_q    <= crd_err_set | (crd_q & ~crd_clr);
      tmr_q    <= tmr_set | (tmr_q & ~tmr_clr);
      con_q    <= {con_stor_set, con_out_set, con_in_set} | (con_q & ~con_clr);
      for (int i = 0; i < NHWL; i++)
        nx_q[i] <= nx_set[i*NSLOT +: NSLOT] | (nx_q[i] & ~nx_clr[i]);
      ack_done <= ack_valid;
      ack_vec  <= vec_d;
      ack_err  <= err_d;
    end
  end
endmodule

// File: rtl/prio_irq_eval_chk.sv
module prio_irq_eval_chk #(
  parameter int LW       = 5,
  parameter int VW       = 16,
  parameter int SW_MAX   = 15,
  parameter int HW_MIN   = 'h14,
  parameter int HW_MAX   = 'h17,
  parameter int LVL_HALT = 'h1F,
  parameter int LVL_MEM  = 'h1D,
  parameter int VEC_MEM  = 'h060
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] cur_ipl,
  input logic          halt_req,
  input logic          ack_valid,
  input logic [LW-1:0] ack_lvl,
  input logic [LW-1:0] irq_lvl,
  input logic          ack_done,
  input logic [VW-1:0] ack_vec,
  input logic          ack_err
);
  p_halt_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> int'(irq_lvl) == LVL_HALT);
  p_above_cur_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && irq_lvl != '0) |-> irq_lvl > cur_ipl);
  p_sw_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_req && int'(cur_ipl) >= SW_MAX && irq_lvl != '0) |-> int'(irq_lvl) >= HW_MIN);
  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> ack_done);
  p_nodone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |=> !ack_done);
  p_mem_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && int'(ack_lvl) == LVL_MEM) |=> (int'(ack_vec) == VEC_MEM && !ack_err));
  p_err_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> (ack_done && ack_vec == '0));
  p_err_lvl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && int'(ack_lvl) == LVL_HALT) |=> ack_err);
endmodule

bind prio_irq_eval prio_irq_eval_chk #(
  .LW(LW), .VW(VW), .SW_MAX(SW_MAX), .HW_MIN(HW_MIN), .HW_MAX(HW_MIN + NHWL - 1),
  .LVL_HALT(LVL_HALT), .LVL_MEM(LVL_MEM), .VEC_MEM(VEC_MEM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_ipl(cur_ipl), .halt_req(halt_req),
  .ack_valid(ack_valid), .ack_lvl(ack_lvl), .irq_lvl(irq_lvl),
  .ack_done(ack_done), .ack_vec(ack_vec), .ack_err(ack_err)
);

// File: tb/sim_prio_irq_eval.sv
`timescale 1ns/1ps
module sim_prio_irq_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cur_ipl = '0;
  logic        halt_req = 1'b0;
  logic        mem_err_set = 1'b0, crd_err_set = 1'b0, tmr_set = 1'b0;
  logic [63:0] nx_set = '0;
  logic        con_in_set = 1'b0, con_out_set = 1'b0, con_stor_set = 1'b0;
  logic [14:0] sw_req = '0;
  logic        ack_valid = 1'b0;
  logic [4:0]  ack_lvl = '0;
  logic [4:0]  irq_lvl;
  logic        ack_done;
  logic [15:0] ack_vec;
  logic        ack_err;

  prio_irq_eval u0 (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bit       m_mem, m_crd, m_tmr;
  bit [2:0] m_con;
  bit [15:0] m_nx [4];
  int e_vec;
  bit e_err, e_done;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_irq();
    int c = cur_ipl;
    if (halt_req) return 31;
    if (m_mem && c < 29) return 29;
    if (m_crd && c < 26) return 26;
    if (m_tmr && c < 24) return 24;
    for (int l = 23; l >= 20; l--) begin
      if (l <= c) return 0;
      if (m_nx[l-20] != 0) return l;
    end
    if (m_con != 0) return 20;
    if (c >= 15) return 0;
    for (int n = 15; n > c; n--) if (sw_req[n-1]) return n;
    return 0;
  endfunction

  task automatic step(string tag);
    bit clr_mem = 0, clr_crd = 0, clr_tmr = 0;
    bit [2:0] clr_con = 0;
    int clr_l = -1, clr_s = 0;
    int a = ack_lvl;
    #1;
    chk(irq_lvl == model_irq(), tag, irq_lvl, model_irq());
    e_done = ack_valid; e_vec = 0; e_err = 0;
    if (ack_valid) begin
      if (a == 29) begin clr_mem = 1; e_vec = 'h060; end
      else if (a == 26) begin clr_crd = 1; e_vec = 'h054; end
      else if (a == 24) begin clr_tmr = 1; e_vec = 'h0C0; end
      else if (a > 23) e_err = 1;
      else if (a >= 20 && m_nx[a-20] != 0) begin
        clr_l = a - 20;
        for (int s = 15; s >= 0; s--) if (m_nx[clr_l][s]) clr_s = s;
        e_vec = 'h100 + clr_l * 64 + clr_s * 4;
      end else if (a == 20) begin
        if (m_con[0]) begin clr_con[0] = 1; e_vec = 'h0F8; end
        else if (m_con[1]) begin clr_con[1] = 1; e_vec = 'h0FC; end
        else if (m_con[2]) begin clr_con[2] = 1; e_vec = 'h0F0; end
      end
    end
    m_mem = mem_err_set | (m_mem & !clr_mem);
    m_crd = crd_err_set | (m_crd & !clr_crd);
    m_tmr = tmr_set | (m_tmr & !clr_tmr);
    m_con = {con_stor_set, con_out_set, con_in_set} | (m_con & ~clr_con);
    for (int l = 0; l < 4; l++) begin
      if (l == clr_l) m_nx[l][clr_s] = 1'b0;
      m_nx[l] = m_nx[l] | nx_set[l*16 +: 16];
    end
    @(posedge clk);
    @(negedge clk);
    chk(ack_done == e_done, tag, ack_done, e_done);
    chk(ack_vec == 16'(e_vec), tag, ack_vec, e_vec);
    chk(ack_err == e_err, tag, ack_err, e_err);
    mem_err_set = 0; crd_err_set = 0; tmr_set = 0; nx_set = '0;
    con_in_set = 0; con_out_set = 0; con_stor_set = 0; ack_valid = 0;
  endtask

  task automatic ack(int l, string tag);
    ack_valid = 1; ack_lvl = 5'(l); step(tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(irq_lvl == 0 && ack_done == 0 && ack_vec == 0 && ack_err == 0, "R11", irq_lvl, 0);
    step("R11");
    // R1
    halt_req = 1; cur_ipl = 31; step("R1");
    cur_ipl = 0; mem_err_set = 1; step("R1");
    halt_req = 0;
    // R2 order
    crd_err_set = 1; tmr_set = 1; nx_set[3*16+3] = 1; con_in_set = 1; sw_req = 15'h4000;
    step("R2");
    ack(29, "R8"); ack(26, "R8"); ack(24, "R8");
    cur_ipl = 29; step("R2");
    cur_ipl = 0; ack(23, "R5");
    step("R2");
    ack(20, "R7");
    step("R4");
    cur_ipl = 15; step("R4");
    sw_req = 15'h0010; cur_ipl = 5; step("R4");
    cur_ipl = 3; step("R4");
    sw_req = 0;
    // R3 / R5 / R6
    nx_set[16+2] = 1; nx_set[16+9] = 1; cur_ipl = 21; step("R3");
    cur_ipl = 20; step("R3");
    ack(21, "R6"); ack(21, "R5"); ack(21, "R9");
    nx_set[3*16+15] = 1; step("R5");
    ack(23, "R5");
    // R7 with shared level
    con_in_set = 1; con_out_set = 1; con_stor_set = 1; nx_set[4] = 1; cur_ipl = 0; step("R7");
    ack(20, "R6"); ack(20, "R7"); ack(20, "R7"); ack(20, "R7"); ack(20, "R9");
    // R9
    ack(31, "R9"); ack(27, "R9"); ack(5, "R9");
    // R10
    mem_err_set = 1; step("R10");
    mem_err_set = 1; ack(29, "R10");
    step("R10");
    ack(29, "R10");
    step("R10");
    // random
    for (int k = 0; k < 4000; k++) begin
      cur_ipl = 5'($urandom_range(0, 31));
      halt_req = ($urandom_range(0, 15) == 0);
      mem_err_set = ($urandom_range(0, 15) == 0);
      crd_err_set = ($urandom_range(0, 15) == 0);
      tmr_set = ($urandom_range(0, 7) == 0);
      con_in_set = ($urandom_range(0, 7) == 0);
      con_out_set = ($urandom_range(0, 7) == 0);
      con_stor_set = ($urandom_range(0, 7) == 0);
      nx_set = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      sw_req = 15'($urandom & $urandom);
      ack_valid = $urandom_range(0, 1) == 1;
      ack_lvl = 5'($urandom_range(0, 2) == 0 ? $urandom_range(0, 31) : $urandom_range(20, 31));
      step("R2");
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule